// File: doc/BRIEF.md
# Microcode Sequencer with Jump Types

This block is the next-address engine of a microprogrammed controller. A 6-bit micro-program counter indexes a built-in control store. Each word in the store holds an 18-bit control vector for the datapath and a 3-bit jump code. The jump code selects how the counter moves on the next clock edge. It can step by one, stall while memory is busy, return to the first fetch step, dispatch on the opcode, or return to fetch depending on the condition flag.

The control vector is a combinational function of the current micro-address. It therefore changes in the same cycle as the counter. The fetch routine occupies addresses 0 to 2. Its third step dispatches through a decode table to the routine for the opcode group. Opcodes missing from that table go to an illegal-instruction routine that ends by returning to fetch.

Top module: `useq_top`

## Requirements
- R1: While rst_ni is low, upc_o is 0 (fetch0). After reset is released, the first micro-address is 0.
- R2: A word with jump code 0 (step) sends the counter to the current address plus one.
- R3: A word with jump code 1 (spin) holds the counter while busy_i is 1. It steps to the address plus one on the first edge where busy_i is 0.
- R4: Jump code 2 (fetch) sends the counter to 0. Codes 6 and 7 behave the same way; the word at 41 carries code 6 and the word at 23 carries code 7.
- R5: Jump code 3 (dispatch) loads a start address chosen by opcode_i: 5'h0C to 3, 5'h04 to 6, 5'h00 to 9, 5'h18 to 14, 5'h1B to 20, 5'h02 to 24, 5'h03 to 31.
- R6: Dispatch on any opcode not listed in R5 loads 40. Address 40 steps to 41, and 41 returns to 0.
- R7: Jump code 4 (return on true) sends the counter to 0 when cond_i is 1 and to the address plus one otherwise. The word at 31 carries this code.
- R8: Jump code 5 (return on false) sends the counter to 0 when cond_i is 0 and to the address plus one otherwise. The word at 16 carries this code.
- R9: The control vector for the current word appears on ctrl_o in the same cycle as its address. At address 0 it is 18'h0180D: register-file enable bit 0, address-latch load bit 2, A load bit 3, and register select bits 12:11 equal to 3. At address 1 it is 18'h00120: IR load bit 5 and memory enable bit 8.
- R10: The fetch routine is address 0 (step), 1 (spin) and 2 (dispatch). The memory-to-memory routine at 24 to 30 spins on busy_i at 25, 27 and 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 5 | Opcode of the current macroinstruction |
| cond_i | input | 1 | Condition flag from the datapath |
| busy_i | input | 1 | Memory busy flag |
| ctrl_o | output | 18 | Control vector of the current micro-word |
| upc_o | output | 6 | Current micro-address |

## Verification
Every jump decision takes effect on the next rising edge. The new micro-address and its control vector are both visible one cycle after the inputs that chose them, and ctrl_o has no further delay. The bench changes opcode_i, cond_i and busy_i only at falling edges. It then waits for exactly one rising edge and samples upc_o and ctrl_o at the next falling edge. This lets it walk every routine one address at a time. Spin holds are checked on each busy cycle before busy_i drops.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W  = 6;
  localparam int OP_W   = 5;
  localparam int CTRL_W = 18;
  localparam int JMP_W  = 3;

  typedef logic [UPC_W-1:0]  upc_t;
  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [JMP_W-1:0]  jmp_t;

  localparam jmp_t J_NEXT   = 3'd0;
  localparam jmp_t J_SPIN   = 3'd1;
  localparam jmp_t J_FETCH  = 3'd2;
  localparam jmp_t J_DISP   = 3'd3;
  localparam jmp_t J_FTRUE  = 3'd4;
  localparam jmp_t J_FFALSE = 3'd5;
  localparam jmp_t J_RSV6   = 3'd6;
  localparam jmp_t J_RSV7   = 3'd7;

  // control bit positions
  localparam int CB_REG_EN = 0;
  localparam int CB_REG_WR = 1;
  localparam int CB_MA_LD  = 2;
  localparam int CB_A_LD   = 3;
  localparam int CB_B_LD   = 4;
  localparam int CB_IR_LD  = 5;
  localparam int CB_PC_LD  = 6;
  localparam int CB_ALU_EN = 7;
  localparam int CB_MEM_EN = 8;
  localparam int CB_MEM_WR = 9;
  localparam int CB_IMM_EN = 10;
  localparam int CB_SEL_LO = 11;  // 2-bit register select
  localparam int CB_IMM_LO = 13;  // 2-bit immediate format
  localparam int CB_ALU_LO = 15;  // 3-bit ALU op

  localparam logic [1:0] SEL_RS1 = 2'd0;
  localparam logic [1:0] SEL_RS2 = 2'd1;
  localparam logic [1:0] SEL_RD  = 2'd2;
  localparam logic [1:0] SEL_PC  = 2'd3;

  localparam logic [1:0] IMM_I = 2'd0;
  localparam logic [1:0] IMM_J = 2'd1;
  localparam logic [1:0] IMM_B = 2'd2;

  localparam logic [2:0] ALU_ADD = 3'd0;
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_FN  = 3'd2;
  localparam logic [2:0] ALU_CMP = 3'd3;

  // routine start addresses
  localparam upc_t A_FETCH0 = 6'd0;
  localparam upc_t A_ALU    = 6'd3;
  localparam upc_t A_ALUI   = 6'd6;
  localparam upc_t A_LOAD   = 6'd9;
  localparam upc_t A_BR     = 6'd14;
  localparam upc_t A_JMP    = 6'd20;
  localparam upc_t A_MMA    = 6'd24;
  localparam upc_t A_SKIPT  = 6'd31;
  localparam upc_t A_ILL    = 6'd40;

  function automatic ctrl_t cbit(input int pos);
    ctrl_t v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic ctrl_t reg_rd(input logic [1:0] sel);
    ctrl_t v;
    v = cbit(CB_REG_EN);
    v[CB_SEL_LO +: 2] = sel;
    return v;
  endfunction

  function automatic ctrl_t reg_wr(input logic [1:0] sel);
    ctrl_t v;
    v = cbit(CB_REG_EN) | cbit(CB_REG_WR);
    v[CB_SEL_LO +: 2] = sel;
    return v;
  endfunction

  function automatic ctrl_t alu(input logic [2:0] op);
    ctrl_t v;
    v = cbit(CB_ALU_EN);
    v[CB_ALU_LO +: 3] = op;
    return v;
  endfunction

  function automatic ctrl_t imm(input logic [1:0] fmt);
    ctrl_t v;
    v = cbit(CB_IMM_EN);
    v[CB_IMM_LO +: 2] = fmt;
    return v;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  upc_t  addr_i,
  output ctrl_t ctrl_o,
  output jmp_t  jmp_o
);
  always_comb begin
    ctrl_o = '0;
    jmp_o  = J_RSV7;
    unique case (addr_i)
      // instruction fetch
      6'd0:  begin ctrl_o = reg_rd(SEL_PC) | cbit(CB_MA_LD) | cbit(CB_A_LD); jmp_o = J_NEXT;  end
      6'd1:  begin ctrl_o = cbit(CB_MEM_EN) | cbit(CB_IR_LD);                jmp_o = J_SPIN;  end
      6'd2:  begin ctrl_o = alu(ALU_ADD) | cbit(CB_PC_LD);                   jmp_o = J_DISP;  end
      // reg-reg ALU
      6'd3:  begin ctrl_o = reg_rd(SEL_RS1) | cbit(CB_A_LD);                 jmp_o = J_NEXT;  end
      6'd4:  begin ctrl_o = reg_rd(SEL_RS2) | cbit(CB_B_LD);                 jmp_o = J_NEXT;  end
      6'd5:  begin ctrl_o = alu(ALU_FN) | reg_wr(SEL_RD);                    jmp_o = J_FETCH; end
      // reg-imm ALU
      6'd6:  begin ctrl_o = reg_rd(SEL_RS1) | cbit(CB_A_LD);                 jmp_o = J_NEXT;  end
      6'd7:  begin ctrl_o = imm(IMM_I) | cbit(CB_B_LD);                      jmp_o = J_NEXT;  end
      6'd8:  begin ctrl_o = alu(ALU_FN) | reg_wr(SEL_RD);                    jmp_o = J_FETCH; end
      // load
      6'd9:  begin ctrl_o = reg_rd(SEL_RS1) | cbit(CB_A_LD);                 jmp_o = J_NEXT;  end
      6'd10: begin ctrl_o = imm(IMM_I) | cbit(CB_B_LD);                      jmp_o = J_NEXT;  end
      6'd11: begin ctrl_o = alu(ALU_ADD) | cbit(CB_MA_LD);                   jmp_o = J_NEXT;  end
      6'd12: begin ctrl_o = cbit(CB_MEM_EN);                                 jmp_o = J_SPIN;  end
      6'd13: begin ctrl_o = cbit(CB_MEM_EN) | reg_wr(SEL_RD);                jmp_o = J_FETCH; end
      // conditional branch
      6'd14: begin ctrl_o = reg_rd(SEL_RS1) | cbit(CB_A_LD);                 jmp_o = J_NEXT;  end
      6'd15: begin ctrl_o = reg_rd(SEL_RS2) | cbit(CB_B_LD);                 jmp_o = J_NEXT;  end
      6'd16: begin ctrl_o = alu(ALU_CMP) | reg_rd(SEL_PC) | cbit(CB_A_LD);   jmp_o = J_FFALSE; end
      6'd17: begin ctrl_o = alu(ALU_SUB) | cbit(CB_A_LD);                    jmp_o = J_NEXT;  end
      6'd18: begin ctrl_o = imm(IMM_B) | cbit(CB_B_LD);                      jmp_o = J_NEXT;  end
      6'd19: begin ctrl_o = alu(ALU_ADD) | cbit(CB_PC_LD);                   jmp_o = J_FETCH; end
      // jump and link; last word uses reserved code 7
      6'd20: begin ctrl_o = reg_wr(SEL_RD);                                  jmp_o = J_NEXT;  end
      6'd21: begin ctrl_o = alu(ALU_SUB) | cbit(CB_A_LD);                    jmp_o = J_NEXT;  end
      6'd22: begin ctrl_o = imm(IMM_J) | cbit(CB_B_LD);                      jmp_o = J_NEXT;  end
      6'd23: begin ctrl_o = alu(ALU_ADD) | cbit(CB_PC_LD);                   jmp_o = J_RSV7;  end
      // memory-memory add
      6'd24: begin ctrl_o = reg_rd(SEL_RS1) | cbit(CB_MA_LD);                jmp_o = J_NEXT;  end
      6'd25: begin ctrl_o = cbit(CB_MEM_EN) | cbit(CB_A_LD);                 jmp_o = J_SPIN;  end
      6'd26: begin ctrl_o = reg_rd(SEL_RS2) | cbit(CB_MA_LD);                jmp_o = J_NEXT;  end
      6'd27: begin ctrl_o = cbit(CB_MEM_EN) | cbit(CB_B_LD);                 jmp_o = J_SPIN;  end
      6'd28: begin ctrl_o = reg_rd(SEL_RD) | cbit(CB_MA_LD);                 jmp_o = J_NEXT;  end
      6'd29: begin ctrl_o = alu(ALU_FN) | cbit(CB_MEM_EN) | cbit(CB_MEM_WR); jmp_o = J_SPIN;  end
      6'd30: begin ctrl_o = '0;                                              jmp_o = J_FETCH; end
      // skip-if-true
      6'd31: begin ctrl_o = alu(ALU_CMP) | reg_rd(SEL_RS1);                  jmp_o = J_FTRUE; end
      6'd32: begin ctrl_o = reg_wr(SEL_RD);                                  jmp_o = J_NEXT;  end
      6'd33: begin ctrl_o = '0;                                              jmp_o = J_FETCH; end
      // illegal instruction; last word uses reserved code 6
      6'd40: begin ctrl_o = reg_rd(SEL_PC) | cbit(CB_A_LD);                  jmp_o = J_NEXT;  end
      6'd41: begin ctrl_o = '0;                                              jmp_o = J_RSV6;  end
      default: begin ctrl_o = '0; jmp_o = J_RSV7; end
    endcase
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output upc_t            start_o
);
  always_comb begin
    unique case (opcode_i)
      5'h0C:   start_o = A_ALU;
      5'h04:   start_o = A_ALUI;
      5'h00:   start_o = A_LOAD;
      5'h18:   start_o = A_BR;
      5'h1B:   start_o = A_JMP;
      5'h02:   start_o = A_MMA;
      5'h03:   start_o = A_SKIPT;
      default: start_o = A_ILL;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  upc_t upc_i,
  input  jmp_t jmp_i,
  input  upc_t disp_i,
  input  logic cond_i,
  input  logic busy_i,
  output upc_t nxt_o
);
  upc_t inc;
  assign inc = upc_i + 1'b1;

  always_comb begin
    unique case (jmp_i)
      J_NEXT:   nxt_o = inc;
      J_SPIN:   nxt_o = busy_i ? upc_i : inc;
      J_DISP:   nxt_o = disp_i;
      J_FTRUE:  nxt_o = cond_i ? A_FETCH0 : inc;
      J_FFALSE: nxt_o = cond_i ? inc : A_FETCH0;
      default:  nxt_o = A_FETCH0;  // fetch and reserved 6/7
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic              cond_i,
  input  logic              busy_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [UPC_W-1:0]  upc_o
);
  upc_t upc_q, upc_d, disp_w;
  jmp_t jump_w;

  useq_rom u_rom (
    .addr_i (upc_q),
    .ctrl_o (ctrl_o),
    .jmp_o  (jump_w)
  );

  useq_decode u_dec (
    .opcode_i (opcode_i),
    .start_o  (disp_w)
  );

  useq_next u_nxt (
    .upc_i  (upc_q),
    .jmp_i  (jump_w),
    .disp_i (disp_w),
    .cond_i (cond_i),
    .busy_i (busy_i),
    .nxt_o  (upc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= A_FETCH0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic cond_i,
  input jmp_t jump_i,
  input upc_t upc_i
);
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_fetch0: assert (upc_i == A_FETCH0);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i == J_NEXT |=> upc_i == upc_t'($past(upc_i) + 1'b1));

  a_r3_spin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i == J_SPIN && busy_i) |=> $stable(upc_i));

  a_r3_spin_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i == J_SPIN && !busy_i) |=> upc_i == upc_t'($past(upc_i) + 1'b1));

  a_r4_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i == J_FETCH || jump_i == J_RSV6 || jump_i == J_RSV7) |=> upc_i == A_FETCH0);

  a_r7_ftrue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i == J_FTRUE && cond_i) |=> upc_i == A_FETCH0);

  a_r8_ffalse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i == J_FFALSE && !cond_i) |=> upc_i == A_FETCH0);
endmodule

bind useq_top useq_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_i),
  .cond_i (cond_i),
  .jump_i (jump_w),
  .upc_i  (upc_o)
);

// File: tb/useq_top_bench.sv
module useq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  opcode_i = '0;
  logic        cond_i = 1'b0;
  logic        busy_i = 1'b0;
  logic [17:0] ctrl_o;
  logic [5:0]  upc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  useq_top u_useq_top (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .cond_i   (cond_i),
    .busy_i   (busy_i),
    .ctrl_o   (ctrl_o),
    .upc_o    (upc_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one rising edge, sample at falling edge
  task automatic step(input int exp, input string tag);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, int'(upc_o), exp);
  endtask

  task automatic do_fetch(input logic [4:0] op, input int start, input string tag);
    opcode_i = op;
    busy_i = 1'b0;
    chk("R10 fetch0", int'(upc_o), 0);
    step(1, "R10 fetch1");
    step(2, "R10 fetch2");
    step(start, tag);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    #(CLK_PERIOD*2);
    @(negedge clk_i);
    chk("R1 upc in reset", int'(upc_o), 0);
    chk("R9 ctrl at fetch0", int'(ctrl_o), 'h0180D);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 first address", int'(upc_o), 1);
    chk("R9 ctrl at fetch1", int'(ctrl_o), 'h00120);
    step(2, "R10 fetch2");
    opcode_i = 5'h0C;
    step(3, "R5 alu start");
    step(4, "R2 step");
    step(5, "R2 step");
    step(0, "R4 code 2 fetch");
  endtask

  task automatic t_alui_spin;
    opcode_i = 5'h04;
    busy_i = 1'b1;
    step(1, "R2 into spin");
    for (int i = 0; i < 3; i++) step(1, "R3 hold while busy");
    busy_i = 1'b0;
    step(2, "R3 release");
    step(6, "R5 alui start");
    step(7, "R2 step");
    step(8, "R2 step");
    step(0, "R4 fetch");
  endtask

  task automatic t_load;
    do_fetch(5'h00, 9, "R5 load start");
    step(10, "R2 step");
    step(11, "R2 step");
    step(12, "R2 step");
    busy_i = 1'b1;
    step(12, "R3 load wait");
    step(12, "R3 load wait");
    busy_i = 1'b0;
    step(13, "R3 load release");
    step(0, "R4 fetch");
  endtask

  task automatic t_branch(input logic c);
    do_fetch(5'h18, 14, "R5 branch start");
    cond_i = c;
    step(15, "R2 step");
    step(16, "R2 step");
    if (!c) step(0, "R8 ffalse cond0 returns");
    else begin
      step(17, "R8 ffalse cond1 steps");
      step(18, "R2 step");
      step(19, "R2 step");
      step(0, "R4 fetch");
    end
    cond_i = 1'b0;
  endtask

  task automatic t_skipt(input logic c);
    do_fetch(5'h03, 31, "R5 skipt start");
    cond_i = c;
    if (c) step(0, "R7 ftrue cond1 returns");
    else begin
      step(32, "R7 ftrue cond0 steps");
      step(33, "R2 step");
      step(0, "R4 fetch");
    end
    cond_i = 1'b0;
  endtask

  task automatic t_jump;
    do_fetch(5'h1B, 20, "R5 jump start");
    step(21, "R2 step");
    step(22, "R2 step");
    step(23, "R2 step");
    step(0, "R4 code 7 fetch");
  endtask

  task automatic t_mma;
    do_fetch(5'h02, 24, "R5 mma start");
    step(25, "R2 step");
    busy_i = 1'b1;
    step(25, "R10 spin 25");
    busy_i = 1'b0;
    step(26, "R10 release 25");
    step(27, "R2 step");
    busy_i = 1'b1;
    step(27, "R10 spin 27");
    busy_i = 1'b0;
    step(28, "R10 release 27");
    step(29, "R2 step");
    busy_i = 1'b1;
    step(29, "R10 spin 29");
    busy_i = 1'b0;
    step(30, "R10 release 29");
    step(0, "R4 fetch");
  endtask

  task automatic t_illegal(input logic [4:0] op);
    do_fetch(op, 40, "R6 illegal start");
    step(41, "R6 illegal step");
    step(0, "R4 code 6 fetch");
  endtask

  initial begin
    t_reset();
    t_alui_spin();
    t_load();
    t_branch(1'b0);
    t_branch(1'b1);
    t_skipt(1'b1);
    t_skipt(1'b0);
    t_jump();
    t_mma();
    t_illegal(5'h1F);
    t_illegal(5'h05);
    chk("R9 ctrl back at fetch0", int'(ctrl_o), 'h0180D);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule